// File: doc/BRIEF.md
# Two-Mode Burst Address Sequencer

This block produces the word address for a pipelined synchronous SRAM while it runs four-beat bursts. A load cycle captures a full external address. The two least significant bits of that address become the starting point of the burst. Each later advance cycle moves those two bits to the next beat, in either wrapping linear order or XOR-based interleaved order. A static strap input picks the order. The upper address bits do not change for the whole burst.

Every control and address input is sampled on the rising clock edge, and only when the active-low clock enable is asserted. When clock enable is deasserted, every register holds its value, which stretches the previous cycle without ending the burst. A deselect cycle (select low) returns the sequencer to its idle state. From idle, an advance request is ignored and only a load can start a new access.

The control is a two-state machine:
- States: `ST_IDLE` (no access in progress, `valid` low) and `ST_BURST` (access in progress, `valid` high).
- Transitions: `ST_IDLE -> ST_BURST` on an enabled load. `ST_BURST -> ST_IDLE` on an enabled deselect. `ST_BURST -> ST_BURST` on an enabled load (restart) or an enabled advance. Every cycle with clock enable deasserted leaves the state unchanged.

Top module: `bseq_top`

## Requirements
- R1: After reset, `valid` is 0 and `addr_out` is all zeros.
- R2: An enabled cycle (`ce_n`=0) with `sel`=1 and `adv_ld`=0 loads `addr_in`. From the next cycle `addr_out` equals that address and `valid` is 1. This applies in both states.
- R3: With `mode_ilv`=0 (linear order), after k enabled advances since the load, `addr_out[1:0]` equals (s + k) mod 4, where s is the loaded value of bits [1:0].
- R4: With `mode_ilv`=1 (interleaved order), after k enabled advances since the load, `addr_out[1:0]` equals s XOR (k mod 4).
- R5: Advances never change `addr_out[18:2]`. Those bits keep the loaded value.
- R6: After four advances, the burst wraps and `addr_out[1:0]` equals the start value again.
- R7: An enabled cycle with `sel`=0 drives `valid` to 0 from the next cycle and leaves `addr_out` unchanged.
- R8: An enabled advance (`sel`=1, `adv_ld`=1) while `valid` is 0 is ignored. `valid` stays 0 and `addr_out` is unchanged.
- R9: A cycle with `ce_n`=1 changes neither `addr_out` nor `valid`, whatever `sel`, `adv_ld` and `addr_in` carry.
- R10: After one or more cycles with `ce_n`=1, the next enabled advance continues the burst from the beat where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low clock enable; high freezes all state |
| sel | input | 1 | Access select; low deselects |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new address |
| mode_ilv | input | 1 | Static strap: 1 = interleaved order, 0 = linear order |
| addr_in | input | 19 | External word address |
| addr_out | output | 19 | Current access address |
| valid | output | 1 | High while an access is in progress |

## Verification
The bench sweeps every start value in both burst orders, with upper addresses that include all ones. It runs six advances per burst to cover the wrap. An adder that dropped the modulo, or a mode mux that swapped the two orders, shows up as a wrong low pair at once. The bench also inserts clock-enable stalls that present a tempting load address on `addr_in`. A design that ignored the enable would load that address or skip a beat. It also issues advances right after reset and right after a deselect. A design that failed to require a load would then raise `valid` or move the address.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bseq_state_t;
endpackage

// File: rtl/bseq_beat.sv
module bseq_beat #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [BW-1:0] beat
);
    localparam logic [BW-1:0] LAST = {BW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            beat <= '0;
        else if (clr)
            beat <= '0;
        else if (inc)
            beat <= beat + 1'b1;
    end

    // R6
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && beat == LAST) |=> (beat == '0));
endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
    parameter int BW = 2
) (
    input  logic          mode_ilv,
    input  logic [BW-1:0] start,
    input  logic [BW-1:0] beat,
    output logic [BW-1:0] low
);
    logic [BW-1:0] lin_v;
    logic [BW-1:0] ilv_v;

    always_comb begin
        lin_v = start + beat;
        ilv_v = start ^ beat;
        low   = mode_ilv ? ilv_v : lin_v;
    end
endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int BW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              sel,
    input  logic              adv_ld,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              valid
);
    localparam int UW = ADDR_W - BW;

    bseq_state_t   state, state_nxt;
    logic [UW-1:0] upper_q;
    logic [BW-1:0] start_q;
    logic [BW-1:0] beat;
    logic [BW-1:0] low;
    logic          do_load;
    logic          do_adv;

    always_comb begin
        do_load   = !ce_n && sel && !adv_ld;
        do_adv    = !ce_n && sel && adv_ld && (state == ST_BURST);
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (do_load) state_nxt = ST_BURST;
            ST_BURST: if (!ce_n && !sel) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (do_load) begin
            upper_q <= addr_in[ADDR_W-1:BW];
            start_q <= addr_in[BW-1:0];
        end
    end

    bseq_beat #(.BW(BW)) i_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_load),
        .inc   (do_adv),
        .beat  (beat)
    );

    bseq_order #(.BW(BW)) i_order (
        .mode_ilv (mode_ilv),
        .start    (start_q),
        .beat     (beat),
        .low      (low)
    );

    always_comb begin
        addr_out = {upper_q, low};
        valid    = (state == ST_BURST);
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && sel && !adv_ld) |=> (valid && addr_out == $past(addr_in)));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ilv && !ce_n && sel && adv_ld && valid)
        |=> (addr_out[BW-1:0] == BW'($past(addr_out[BW-1:0]) + 1'b1)));

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && sel && adv_ld) |=> $stable(addr_out[ADDR_W-1:BW]));

    // R7
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !sel) |=> (!valid && $stable(addr_out)));

    // R8
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && sel && adv_ld && !valid) |=> (!valid && $stable(addr_out)));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> ($stable(addr_out) && $stable(valid)));
endmodule

// File: tb/test_bseq_top.sv
module test_bseq_top;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          sel = 1'b0;
    logic          adv_ld = 1'b0;
    logic          mode_ilv = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bseq_top i_bseq_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .sel      (sel),
        .adv_ld   (adv_ld),
        .mode_ilv (mode_ilv),
        .addr_in  (addr_in),
        .addr_out (addr_out),
        .valid    (valid)
    );

    task automatic check(input string req, input logic [AW-1:0] exp_a, input logic exp_v);
        checks++;
        if (addr_out !== exp_a || valid !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h valid=%b expected addr=%h valid=%b",
                     req, addr_out, valid, exp_a, exp_v);
        end
    endtask

    task automatic cyc(input logic c, input logic s, input logic a, input logic [AW-1:0] ad);
        @(negedge clk);
        ce_n = c; sel = s; adv_ld = a; addr_in = ad;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mode_ilv = m; ce_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [AW-1:0] exp_a;
        logic [16:0]   uppers [3];
        uppers[0] = 17'h00000; uppers[1] = 17'h15A5A; uppers[2] = 17'h1FFFF;

        do_reset(1'b1);
        check("R1", '0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 19'h7FFFF);
        check("R8", '0, 1'b0);

        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            for (int u = 0; u < 3; u++) begin
                for (int s = 0; s < 4; s++) begin
                    exp_a = {uppers[u], s[1:0]};
                    cyc(1'b0, 1'b1, 1'b0, exp_a);
                    check("R2", exp_a, 1'b1);
                    for (int k = 1; k <= 6; k++) begin
                        if (k % 3 == 0) begin
                            cyc(1'b1, 1'b1, 1'b0, ~exp_a);
                            check("R9", exp_a, 1'b1);
                            cyc(1'b1, 1'b0, 1'b1, 19'h0);
                            check("R9", exp_a, 1'b1);
                        end
                        cyc(1'b0, 1'b1, 1'b1, ~exp_a);
                        if (m == 1)
                            exp_a[1:0] = s[1:0] ^ 2'(k % 4);
                        else
                            exp_a[1:0] = 2'((s + k) % 4);
                        exp_a[18:2] = uppers[u];
                        if (k % 3 == 0)
                            check("R10", exp_a, 1'b1);
                        else if (k == 4)
                            check("R6", exp_a, 1'b1);
                        else if (m == 1)
                            check("R4", exp_a, 1'b1);
                        else
                            check("R3", exp_a, 1'b1);
                    end
                    check("R5", {uppers[u], exp_a[1:0]}, 1'b1);
                end
                cyc(1'b0, 1'b0, 1'b1, 19'h12345);
                check("R7", exp_a, 1'b0);
                cyc(1'b0, 1'b1, 1'b1, 19'h12345);
                check("R8", exp_a, 1'b0);
                cyc(1'b1, 1'b1, 1'b0, 19'h54321);
                check("R9", exp_a, 1'b0);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule